// File: doc/BRIEF.md
# Tiled Surface Address Calculator

This block turns the description of one surface and a starting point inside it into the register values a copy engine needs before it can walk that surface. The description covers the tile mode, width, height, bytes per pixel and a 40-bit base address. The starting point is given as x, y and z coordinates.

For a tiled surface, the block splits each coordinate into a tile index and an offset inside the tile. It rounds the surface size up to whole tiles. From these it produces four values:
- the byte address of the first element, with the carry out of the low word placed in a separate high config word;
- the pitch between rows of tiles;
- a packed y-tile descriptor;
- a combined y/z tile size.

For a linear surface the block skips all of this. It hands the base address and a caller-supplied pitch straight through.

A request is a one-cycle `start` pulse with all operands held valid in that cycle. The block captures the operands on that edge. A linear request answers one cycle later. A tiled request goes through four registered arithmetic stages and answers five cycles after `start`. Each answer is a one-cycle `done` pulse, and the result outputs hold their values until the next request completes.

Top module: `tiled_addr_calc`

## Requirements
- R1: After reset `done` is 0 and `addr_lo`, `cfg_hi`, `pitch`, `ytile` and `yz_size` are all 0.
- R2: `tile_mode` carries three shift amounts. Bits [3:0] give Tp (log2 of tile width in bytes), bits [7:4] give Th (log2 of tile height in rows) and bits [11:8] give Td (log2 of tile depth in slices).
- R3: For a tiled request, the block first forms these intermediate values, with xb = x*cpp:
  - Txo = xb mod 2^Tp and Tx = xb >> Tp;
  - Tyo = y mod 2^Th and Ty = y >> Th;
  - Tzo = z mod 2^Td and Tz = z >> Td;
  - nTx = ceil(width*cpp / 2^Tp) and nTy = ceil(height / 2^Th).
  
  The offset is off = ((Tz*nTy*nTx + Ty*nTx + Tx) << (Tp+Th+Td)) + (Tzo << (Tp+Th)) + (Tyo << Tp) + Txo, kept to 48 bits. With s = base_lo + off, the outputs are `addr_lo` = s[31:0] and `cfg_hi` = {s[47:32], 8'h00, base_hi}.
- R4: For a tiled request `pitch` = the low 32 bits of (nTx-1) << (Tp+Th+Td).
- R5: For a tiled request `ytile` = (2^Th << 12) | (2^Th - Tyo).
- R6: For a tiled request `yz_size` = (2^Th >> 2) << Td, which is 0 whenever Th < 2.
- R7: For a linear request (`linear`=1), `addr_lo` = base_lo, `cfg_hi` = {24'h0, base_hi}, `pitch` = lin_pitch, `ytile` = 0 and `yz_size` = 0. `done` is high in the cycle after the `start` cycle.
- R8: For a tiled request `done` rises exactly five cycles after the `start` cycle and stays high for one cycle, unless a new request completes right after it.
- R9: A `start` seen while a tiled request is in progress is ignored. It neither changes that request's results nor produces a `done` of its own.
- R10: A `start` in the cycle `done` is high is accepted. The outputs keep the finished result in that cycle and change only when the new request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request pulse; operands sampled with it |
| linear | input | 1 | 1 = linear surface pass-through, 0 = tiled |
| tile_mode | input | 12 | Tp in [3:0], Th in [7:4], Td in [11:8] |
| width | input | XW (19) | Surface width in pixels |
| height | input | YW (13) | Surface height in rows |
| x_pos | input | XW (19) | Starting x in pixels |
| y_pos | input | YW (13) | Starting y in rows |
| z_pos | input | ZW (12) | Starting z slice |
| cpp | input | CPPW (5) | Bytes per pixel |
| base_hi | input | 8 | Base address bits 39:32 |
| base_lo | input | 32 | Base address bits 31:0 |
| lin_pitch | input | 32 | Pitch forwarded for linear surfaces |
| done | output | 1 | Result valid pulse |
| addr_lo | output | 32 | Low word of the first-element address |
| cfg_hi | output | 32 | Base high byte in [7:0], address carry in [31:16] |
| pitch | output | 32 | Tile-row pitch, or forwarded linear pitch |
| ytile | output | 32 | Packed y-tile descriptor |
| yz_size | output | 32 | Combined y/z tile size |

## Verification
Two functions can land in the same cycle: completing one request and accepting the next. The bench provokes this by raising `start` with fresh linear operands in the very cycle a tiled `done` is seen. In that cycle it checks that the outputs still hold the tiled result. One cycle later it checks for a second `done` carrying the linear values. A second overlap drives a `start` two cycles into a tiled request. The bench then checks that no early `done` appears and that the eventual result belongs to the first request.

// File: rtl/tac_pkg.sv
package tac_pkg;
  localparam int CW = 64;
  typedef logic [CW-1:0] word_t;

  typedef enum logic [2:0] {S_IDLE, S_A, S_B, S_C, S_D} tac_state_t;

  // mask of the low 'sh' bits
  function automatic word_t f_lo_mask(input logic [3:0] sh);
    return (word_t'(1) << sh) - word_t'(1);
  endfunction

  // round up to whole units of 2^sh, then count them
  function automatic word_t f_ceil_shr(input word_t v, input logic [3:0] sh);
    return (v + f_lo_mask(sh)) >> sh;
  endfunction

  function automatic logic [31:0] f_shl32(input word_t v, input logic [5:0] s);
    word_t r;
    r = v << s;
    return r[31:0];
  endfunction

  function automatic logic [47:0] f_low48(input word_t v);
    return v[47:0];
  endfunction

  function automatic logic [31:0] f_ytile(input logic [3:0] th, input word_t tyo);
    word_t unit;
    word_t r;
    unit = word_t'(1) << th;
    r = (unit << 12) | (unit - tyo);
    return r[31:0];
  endfunction

  function automatic logic [31:0] f_yzsize(input logic [3:0] th, input logic [3:0] td);
    word_t r;
    r = ((word_t'(1) << th) >> 2) << td;
    return r[31:0];
  endfunction
endpackage

// File: rtl/tac_ctrl.sv
module tac_ctrl
  import tac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic linear,
  output logic idle,
  output logic accept,
  output logic st_a,
  output logic st_b,
  output logic st_c,
  output logic st_d,
  output logic fin,
  output logic done
);
  tac_state_t state;

  assign idle   = (state == S_IDLE);
  assign accept = start & idle;
  assign st_a   = (state == S_A);
  assign st_b   = (state == S_B);
  assign st_c   = (state == S_C);
  assign st_d   = (state == S_D);
  assign fin    = st_d | (accept & linear);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      done <= fin;
      unique case (state)
        S_IDLE:  if (accept && !linear) state <= S_A;
        S_A:     state <= S_B;
        S_B:     state <= S_C;
        S_C:     state <= S_D;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_LIN_NEXT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && linear |=> done); // R7
  AST_TILE_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !linear |=> !done); // R8
  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    st_b |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle); // R10
endmodule

// File: rtl/tac_datapath.sv
module tac_datapath
  import tac_pkg::*;
#(
  parameter int XW   = 19,
  parameter int YW   = 13,
  parameter int ZW   = 12,
  parameter int CPPW = 5,
  parameter int OFFW = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle,
  input  logic            accept,
  input  logic            linear,
  input  logic            st_a,
  input  logic            st_b,
  input  logic            st_c,
  input  logic            st_d,
  input  logic            fin,
  input  logic [11:0]     tile_mode,
  input  logic [XW-1:0]   width,
  input  logic [YW-1:0]   height,
  input  logic [XW-1:0]   x_pos,
  input  logic [YW-1:0]   y_pos,
  input  logic [ZW-1:0]   z_pos,
  input  logic [CPPW-1:0] cpp,
  input  logic [7:0]      base_hi,
  input  logic [31:0]     base_lo,
  input  logic [31:0]     lin_pitch,
  output logic [31:0]     addr_lo,
  output logic [31:0]     cfg_hi,
  output logic [31:0]     pitch,
  output logic [31:0]     ytile,
  output logic [31:0]     yz_size
);
  localparam int SUMW = OFFW + 1;

  logic [11:0]     c_mode;
  logic [XW-1:0]   c_w, c_x;
  logic [YW-1:0]   c_h, c_y;
  logic [ZW-1:0]   c_z;
  logic [CPPW-1:0] c_cpp;
  logic [7:0]      c_bhi;
  logic [31:0]     c_blo;

  logic [3:0] tp, th, td;
  logic [5:0] ts;
  word_t xb, wb;
  word_t r_ntx, r_nty, r_tx, r_txo, r_ty, r_tyo, r_tz, r_tzo;
  word_t r_m1, r_m2, r_idx, r_in;
  word_t off;
  logic [SUMW-1:0] sum;

  assign tp  = c_mode[3:0];
  assign th  = c_mode[7:4];
  assign td  = c_mode[11:8];
  assign ts  = {2'b00, tp} + {2'b00, th} + {2'b00, td};
  assign xb  = word_t'(c_x) * word_t'(c_cpp);
  assign wb  = word_t'(c_w) * word_t'(c_cpp);
  assign off = (r_idx << ts) + r_in;
  assign sum = SUMW'(c_blo) + SUMW'(f_low48(off));

  // operand capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_mode <= '0; c_w <= '0; c_x <= '0; c_h <= '0; c_y <= '0;
      c_z <= '0; c_cpp <= '0; c_bhi <= '0; c_blo <= '0;
    end else if (accept) begin
      c_mode <= tile_mode; c_w <= width; c_x <= x_pos; c_h <= height;
      c_y <= y_pos; c_z <= z_pos; c_cpp <= cpp; c_bhi <= base_hi;
      c_blo <= base_lo;
    end
  end

  // arithmetic stages A..C
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_ntx <= '0; r_nty <= '0; r_tx <= '0; r_txo <= '0;
      r_ty <= '0; r_tyo <= '0; r_tz <= '0; r_tzo <= '0;
      r_m1 <= '0; r_m2 <= '0; r_idx <= '0; r_in <= '0;
    end else begin
      if (st_a) begin
        r_ntx <= f_ceil_shr(wb, tp);
        r_nty <= f_ceil_shr(word_t'(c_h), th);
        r_tx  <= xb >> tp;
        r_txo <= xb & f_lo_mask(tp);
        r_ty  <= word_t'(c_y) >> th;
        r_tyo <= word_t'(c_y) & f_lo_mask(th);
        r_tz  <= word_t'(c_z) >> td;
        r_tzo <= word_t'(c_z) & f_lo_mask(td);
      end
      if (st_b) begin
        r_m1 <= r_tz * r_nty;
        r_m2 <= r_ty * r_ntx;
      end
      if (st_c) begin
        r_idx <= r_m1 * r_ntx + r_m2 + r_tx;
        r_in  <= ((r_tzo << tp) << th) + (r_tyo << tp) + r_txo;
      end
    end
  end

  // result registers, written only on completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo <= '0; cfg_hi <= '0; pitch <= '0; ytile <= '0; yz_size <= '0;
    end else if (st_d) begin
      addr_lo <= sum[31:0];
      cfg_hi  <= {sum[47:32], 8'h00, c_bhi};
      pitch   <= f_shl32(r_ntx - word_t'(1), ts);
      ytile   <= f_ytile(th, r_tyo);
      yz_size <= f_yzsize(th, td);
    end else if (accept && linear) begin
      addr_lo <= base_lo;
      cfg_hi  <= {24'h0, base_hi};
      pitch   <= lin_pitch;
      ytile   <= '0;
      yz_size <= '0;
    end
  end

  AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(c_blo) && $stable(c_mode)); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(addr_lo) && $stable(pitch) && $stable(ytile)); // R10
  AST_YTILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    st_d && th < 4'd12 |=> ytile[11:0] != 12'h0); // R5
endmodule

// File: rtl/tiled_addr_calc.sv
module tiled_addr_calc
  import tac_pkg::*;
#(
  parameter int XW   = 19,
  parameter int YW   = 13,
  parameter int ZW   = 12,
  parameter int CPPW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            linear,
  input  logic [11:0]     tile_mode,
  input  logic [XW-1:0]   width,
  input  logic [YW-1:0]   height,
  input  logic [XW-1:0]   x_pos,
  input  logic [YW-1:0]   y_pos,
  input  logic [ZW-1:0]   z_pos,
  input  logic [CPPW-1:0] cpp,
  input  logic [7:0]      base_hi,
  input  logic [31:0]     base_lo,
  input  logic [31:0]     lin_pitch,
  output logic            done,
  output logic [31:0]     addr_lo,
  output logic [31:0]     cfg_hi,
  output logic [31:0]     pitch,
  output logic [31:0]     ytile,
  output logic [31:0]     yz_size
);
  logic idle, accept, st_a, st_b, st_c, st_d, fin;

  tac_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .linear(linear),
    .idle(idle), .accept(accept), .st_a(st_a), .st_b(st_b), .st_c(st_c),
    .st_d(st_d), .fin(fin), .done(done)
  );

  tac_datapath #(.XW(XW), .YW(YW), .ZW(ZW), .CPPW(CPPW), .OFFW(48)) u_dp (
    .clk(clk), .rst_n(rst_n), .idle(idle), .accept(accept), .linear(linear),
    .st_a(st_a), .st_b(st_b), .st_c(st_c), .st_d(st_d), .fin(fin),
    .tile_mode(tile_mode), .width(width), .height(height),
    .x_pos(x_pos), .y_pos(y_pos), .z_pos(z_pos), .cpp(cpp),
    .base_hi(base_hi), .base_lo(base_lo), .lin_pitch(lin_pitch),
    .addr_lo(addr_lo), .cfg_hi(cfg_hi), .pitch(pitch),
    .ytile(ytile), .yz_size(yz_size)
  );

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(accept && linear) || $past(st_d)); // R8
endmodule

// File: tb/tiled_addr_calc_tb.sv
module tiled_addr_calc_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, linear = 1'b0;
  logic [11:0] tile_mode = '0;
  logic [18:0] width = '0, x_pos = '0;
  logic [12:0] height = '0, y_pos = '0;
  logic [11:0] z_pos = '0;
  logic [4:0]  cpp = '0;
  logic [7:0]  base_hi = '0;
  logic [31:0] base_lo = '0, lin_pitch = '0;
  logic        done;
  logic [31:0] addr_lo, cfg_hi, pitch, ytile, yz_size;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiled_addr_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .linear(linear),
    .tile_mode(tile_mode), .width(width), .height(height),
    .x_pos(x_pos), .y_pos(y_pos), .z_pos(z_pos), .cpp(cpp),
    .base_hi(base_hi), .base_lo(base_lo), .lin_pitch(lin_pitch),
    .done(done), .addr_lo(addr_lo), .cfg_hi(cfg_hi), .pitch(pitch),
    .ytile(ytile), .yz_size(yz_size)
  );

  typedef struct {
    logic [31:0] a, c, p, y, yz;
  } res_t;

  res_t exp_r;

  task automatic chk(input string req, input longint unsigned act, input longint unsigned expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // bench model, written with division and modulo
  function automatic res_t model(input logic lin);
    res_t r;
    longint unsigned tw, thh, tdd, xb, ntx, nty, tx, txo, ty, tyo, tz, tzo, idx, off, s, full;
    if (lin) begin
      r.a = base_lo; r.c = {24'h0, base_hi}; r.p = lin_pitch; r.y = 0; r.yz = 0;
      return r;
    end
    tw  = 64'd1 << tile_mode[3:0];
    thh = 64'd1 << tile_mode[7:4];
    tdd = 64'd1 << tile_mode[11:8];
    xb  = longint'(x_pos) * longint'(cpp);
    ntx = (longint'(width) * longint'(cpp) + tw - 1) / tw;
    nty = (longint'(height) + thh - 1) / thh;
    tx = xb / tw;  txo = xb % tw;
    ty = longint'(y_pos) / thh; tyo = longint'(y_pos) % thh;
    tz = longint'(z_pos) / tdd; tzo = longint'(z_pos) % tdd;
    idx = tz * nty * ntx + ty * ntx + tx;
    off = idx * tw * thh * tdd + tzo * tw * thh + tyo * tw + txo;
    off = off % (64'd1 << 48);
    s = longint'(base_lo) + off;
    r.a = s[31:0];
    r.c = {s[47:32], 8'h00, base_hi};
    full = (ntx - 1) * tw * thh * tdd;
    r.p = full[31:0];
    r.y = 32'(thh * 4096 + (thh - tyo));
    r.yz = 32'((thh / 4) * tdd);
    return r;
  endfunction

  task automatic set_rand(input logic lin);
    linear    = lin;
    tile_mode = {4'($urandom_range(0, 4)), 4'($urandom_range(0, 6)), 4'($urandom_range(0, 7))};
    width     = 19'($urandom_range(1, 524287));
    height    = 13'($urandom_range(1, 8191));
    x_pos     = 19'($urandom_range(0, 524287));
    y_pos     = 13'($urandom_range(0, 8191));
    z_pos     = 12'($urandom_range(0, 4095));
    cpp       = 5'($urandom_range(1, 16));
    base_hi   = 8'($urandom);
    base_lo   = $urandom;
    lin_pitch = $urandom;
  endtask

  task automatic cmp(input string tag, input res_t e);
    chk({tag, " addr_lo"}, addr_lo, e.a);
    chk({tag, " cfg_hi"},  cfg_hi,  e.c);
    chk({tag, " pitch"},   pitch,   e.p);
    chk({tag, " ytile"},   ytile,   e.y);
    chk({tag, " yz_size"}, yz_size, e.yz);
  endtask

  // issue one request at a negedge, return cycles until done
  task automatic issue(output int lat);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic one_op(input string tag, input logic lin);
    int lat;
    res_t e;
    e = model(lin);
    issue(lat);
    chk({tag, lin ? " R7 latency" : " R8 latency"}, lat, lin ? 1 : 5);
    cmp(tag, e);
    if (!lin) begin
      @(negedge clk);
      chk("R8 done single pulse", done, 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int lat;
    res_t e1, e2;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", done, 0);
    chk("R1 addr_lo", addr_lo, 0);
    chk("R1 cfg_hi", cfg_hi, 0);
    chk("R1 pitch", pitch, 0);
    chk("R1 ytile", ytile, 0);
    chk("R1 yz_size", yz_size, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: all-zero shifts and origin (R2, R6 yz=0 when Th<2)
    set_rand(1'b0);
    tile_mode = 12'h000; x_pos = 0; y_pos = 0; z_pos = 0;
    one_op("R2 R6 zero-shift", 1'b0);

    // directed: tile mode fields each non-zero, in-tile offsets maximal (R3, R5)
    set_rand(1'b0);
    tile_mode = 12'h356; cpp = 5'd4; x_pos = 19'd15; y_pos = 13'd31; z_pos = 12'd7;
    one_op("R2 R3 R5 field pos", 1'b0);

    // directed: carry into cfg_hi upper half (R3) and pitch (R4)
    set_rand(1'b0);
    tile_mode = 12'h464; base_lo = 32'hFFFF_FFF0; width = 19'd4096; cpp = 5'd8;
    x_pos = 19'd70000; y_pos = 13'd5000; z_pos = 12'd4000; height = 13'd8000;
    one_op("R3 R4 carry", 1'b0);

    // directed linear pass-through (R7)
    set_rand(1'b1);
    one_op("R7 linear", 1'b1);

    // random mix
    for (int i = 0; i < 60; i++) begin
      set_rand(1'($urandom_range(0, 3) == 0));
      one_op(linear ? "R7 rand" : "R3 R4 R5 R6 rand", linear);
    end

    // R9: start while busy is ignored
    set_rand(1'b0);
    e1 = model(1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    set_rand(1'b1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 no done from busy start", done, 0);
    @(negedge clk);
    chk("R9 still no done", done, 0);
    lat = 4;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk("R9 latency of first op", lat, 5);
    cmp("R9 first result kept", e1);
    @(negedge clk);
    chk("R9 no extra done", done, 0);

    // R10: start in the done cycle is accepted
    set_rand(1'b0);
    e1 = model(1'b0);
    issue(lat);
    chk("R10 first latency", lat, 5);
    cmp("R10 result in done cycle", e1);
    set_rand(1'b1);
    e2 = model(1'b1);
    start = 1'b1;
    cmp("R10 held while new start", e1);
    @(negedge clk);
    start = 1'b0;
    chk("R10 second done", done, 1);
    cmp("R10 second result", e2);
    @(negedge clk);
    chk("R10 done drops", done, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule